// File: doc/BRIEF.md
# Display Command Stream Register Decoder

This block sits behind the byte transport of a display controller. It takes one command byte per valid/ready handshake. Each command opens with a sync byte, and the byte after it is an opcode. Register-write commands land in a shadow register file. The live video register outputs, which drive a timing generator, change only when the stream writes the unlock code to the gate register. At that point the whole shadow file is copied to the live side in one clock. Block-copy commands are gathered into a source address, a pixel count and a destination address, and are offered on a request port.

Back-pressure works at both edges. On the input side, `in_ready` is low for as long as a copy request is waiting. So the upstream source stalls without losing data, and a byte moves only in a cycle where `in_valid` and `in_ready` are both high. On the output side, a request stays on `req_*` with `req_valid` high and does not change until `req_ready` is sampled high. Two conditions are reported on plain status pins: a byte that arrives where the sync byte should be, and an unknown opcode.

Top module: `vidcmd_decoder`

## Requirements
- R1: After reset, `in_ready`=1, `req_valid`=0, `sync_err`=0, `op_err`=0, `regs_locked`=0 and every live register byte is 0.
- R2: A command starts with sync byte 0xAF. Any other byte accepted where a sync byte is expected is dropped and sets `sync_err`, which then stays at 1 until reset. Decoding resumes at the next 0xAF.
- R3: Opcode 0x20 is a 4-byte register write: sync, opcode, index, value. It stores the value in shadow register `index` when index < NREG. Any other index except 0xFF leaves every register unchanged.
- R4: A register write to index 0xFF is a gate. Value 0x00 sets `regs_locked`. Value 0xFF clears `regs_locked` and copies every shadow register to the live outputs on the clock edge that accepts that value byte. Any other value has no effect.
- R5: The live registers keep their values until a gate-open write arrives, whether or not the registers are locked.
- R6: Opcode 0x6A is a 9-byte copy: sync, opcode, a 3-byte source address, a 1-byte pixel count and a 3-byte destination address. Both addresses arrive most significant byte first. `req_valid` goes high on the edge that accepts the last byte.
- R7: While `req_valid` is high and `req_ready` is low, `req_src`, `req_count` and `req_dst` stay stable and `in_ready` is 0.
- R8: An opcode other than 0x20 or 0x6A raises `op_err` for exactly one cycle after it is accepted. The next byte is then treated as a sync byte.
- R9: `fb16_base` is live registers 0x20,0x21,0x22 and `fb8_base` is 0x26,0x27,0x28, with the lowest index as the most significant byte.
- R10: `pix_clk_5k` takes its low byte from live register 0x1B and its high byte from 0x1C. `h_active` is {0x0F,0x10} and `v_active` is {0x17,0x18}, with the high byte at the lower index.
- R11: `deep_color` is 1 exactly when live register 0x00 is nonzero. `blank_code` equals live register 0x1F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Command byte present |
| in_data | input | 8 | Command byte |
| in_ready | output | 1 | Decoder takes a byte this cycle |
| req_valid | output | 1 | Copy request present |
| req_ready | input | 1 | Consumer takes the copy request |
| req_src | output | 24 | Copy source address |
| req_count | output | 8 | Copy pixel count |
| req_dst | output | 24 | Copy destination address |
| regs_locked | output | 1 | Gate closed |
| sync_err | output | 1 | Sticky bad-sync flag |
| op_err | output | 1 | One-cycle unknown-opcode pulse |
| live_regs | output | NREG*8 | All live registers, byte k at bits 8k+7..8k |
| deep_color | output | 1 | 24-bit mode selected |
| blank_code | output | 8 | Live blanking code |
| fb16_base | output | 24 | 16bpp plane base |
| fb8_base | output | 24 | 8bpp plane base |
| pix_clk_5k | output | 16 | Pixel clock in 5 kHz units |
| h_active | output | 16 | Active pixels per line |
| v_active | output | 16 | Active lines |

## Verification
The hardest case to reach is a copy request that is stalled on its output while the upstream source keeps offering bytes. In that state the input must stay closed and the request fields must hold still. The stimulus produces it by forcing `req_ready` low from the monitor before the copy is sent. The driver then keeps `in_valid` high with the next command for several cycles before the consumer releases. Separately, shadow writes made with the gate both closed and open, together with gate writes of a neutral value and writes to indices past the file, are each followed by a live compare. This shows that only the gate-open code moves data to the live side.

// File: rtl/vidcmd_pkg.sv
package vidcmd_pkg;
  localparam logic [7:0] SYNC_BYTE  = 8'hAF;
  localparam logic [7:0] OP_REGWR   = 8'h20;
  localparam logic [7:0] OP_COPY    = 8'h6A;
  localparam logic [7:0] IDX_GATE   = 8'hFF;
  localparam logic [7:0] GATE_CLOSE = 8'h00;
  localparam logic [7:0] GATE_OPEN  = 8'hFF;

  localparam int LOC_DEPTH = 'h00;
  localparam int LOC_HACT  = 'h0F;
  localparam int LOC_VACT  = 'h17;
  localparam int LOC_PCLK  = 'h1B;
  localparam int LOC_BLANK = 'h1F;
  localparam int LOC_FB16  = 'h20;
  localparam int LOC_FB8   = 'h26;

  typedef enum logic [2:0] {
    P_SYNC, P_OPC, P_IDX, P_VAL, P_COPY
  } pstate_t;
endpackage

// File: rtl/vidcmd_parser.sv
module vidcmd_parser
  import vidcmd_pkg::*;
#(
  parameter int COPY_BYTES = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  input  logic       req_pending,
  output logic       wr_en,
  output logic [7:0] wr_idx,
  output logic [7:0] wr_data,
  output logic       cp_shift,
  output logic       cp_last,
  output logic       sync_err,
  output logic       op_err
);
  localparam int CW = $clog2(COPY_BYTES + 1);
  localparam logic [CW-1:0] LAST = CW'(COPY_BYTES - 1);

  pstate_t       state;
  logic [7:0]    idx_q;
  logic [CW-1:0] cnt;
  logic          take;

  assign in_ready = !req_pending;
  assign take     = in_valid && in_ready;
  assign wr_en    = take && (state == P_VAL);
  assign wr_idx   = idx_q;
  assign wr_data  = in_data;
  assign cp_shift = take && (state == P_COPY);
  assign cp_last  = cp_shift && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= P_SYNC;
      idx_q    <= '0;
      cnt      <= '0;
      sync_err <= 1'b0;
      op_err   <= 1'b0;
    end else begin
      op_err <= 1'b0;
      if (take) begin
        unique case (state)
          P_SYNC: begin
            if (in_data == SYNC_BYTE) state <= P_OPC;
            else sync_err <= 1'b1;
          end
          P_OPC: begin
            if (in_data == OP_REGWR) begin
              state <= P_IDX;
            end else if (in_data == OP_COPY) begin
              state <= P_COPY;
              cnt   <= '0;
            end else begin
              op_err <= 1'b1;
              state  <= P_SYNC;
            end
          end
          P_IDX: begin
            idx_q <= in_data;
            state <= P_VAL;
          end
          P_VAL: state <= P_SYNC;
          P_COPY: begin
            if (cnt == LAST) state <= P_SYNC;
            else cnt <= cnt + 1'b1;
          end
          default: state <= P_SYNC;
        endcase
      end
    end
  end

  // R2: once raised the flag never drops before reset
  a_r2_sync_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |=> sync_err);
  // R8: error indication lasts a single cycle
  a_r8_op_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    op_err |=> !op_err);
  // R8: after a bad opcode the decoder waits for a sync byte
  a_r8_back_to_sync: assert property (@(posedge clk) disable iff (!rst_n)
    op_err |-> state == P_SYNC);
endmodule

// File: rtl/vidcmd_copyport.sv
module vidcmd_copyport #(
  parameter int AW = 24,
  parameter int CNTW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cp_shift,
  input  logic            cp_last,
  input  logic [7:0]      cp_byte,
  output logic            req_valid,
  input  logic            req_ready,
  output logic [AW-1:0]   req_src,
  output logic [CNTW-1:0] req_count,
  output logic [AW-1:0]   req_dst
);
  localparam int TOTW = 2 * AW + CNTW;

  logic [TOTW-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh        <= '0;
      req_valid <= 1'b0;
    end else begin
      if (cp_shift) sh <= {sh[TOTW-9:0], cp_byte};
      if (cp_last) req_valid <= 1'b1;
      else if (req_valid && req_ready) req_valid <= 1'b0;
    end
  end

  assign req_src   = sh[TOTW-1 -: AW];
  assign req_count = sh[AW +: CNTW];
  assign req_dst   = sh[AW-1:0];

  // R7: a waiting request keeps its contents
  a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(sh));
  // R7: no payload byte may arrive while a request waits
  a_r7_no_shift_pending: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !cp_shift);
endmodule

// File: rtl/vidcmd_regfile.sv
module vidcmd_regfile
  import vidcmd_pkg::*;
#(
  parameter int NREG = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [7:0]      wr_idx,
  input  logic [7:0]      wr_data,
  output logic            locked,
  output logic [NREG*8-1:0] live_flat
);
  logic commit;

  assign commit = wr_en && (wr_idx == IDX_GATE) && (wr_data == GATE_OPEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) locked <= 1'b0;
    else if (wr_en && wr_idx == IDX_GATE) begin
      if (wr_data == GATE_CLOSE) locked <= 1'b1;
      else if (wr_data == GATE_OPEN) locked <= 1'b0;
    end
  end

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    logic [7:0] sh_q;
    logic [7:0] lv_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q <= '0;
        lv_q <= '0;
      end else begin
        if (wr_en && wr_idx == 8'(k)) sh_q <= wr_data;
        if (commit) lv_q <= sh_q;
      end
    end
    assign live_flat[k*8 +: 8] = lv_q;
  end

  // R5: live side only moves on a gate-open write
  a_r5_live_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_idx == IDX_GATE && wr_data == GATE_OPEN) |=> $stable(live_flat));
  // R4: gate-close write leaves the file locked
  a_r4_lock: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_idx == IDX_GATE && wr_data == GATE_CLOSE |=> locked);
  // R4: gate-open write leaves the file unlocked
  a_r4_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_idx == IDX_GATE && wr_data == GATE_OPEN |=> !locked);
endmodule

// File: rtl/vidcmd_decoder.sv
module vidcmd_decoder
  import vidcmd_pkg::*;
#(
  parameter int NREG = 64,
  parameter int AW = 24,
  parameter int CNTW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [AW-1:0]     req_src,
  output logic [CNTW-1:0]   req_count,
  output logic [AW-1:0]     req_dst,
  output logic              regs_locked,
  output logic              sync_err,
  output logic              op_err,
  output logic [NREG*8-1:0] live_regs,
  output logic              deep_color,
  output logic [7:0]        blank_code,
  output logic [23:0]       fb16_base,
  output logic [23:0]       fb8_base,
  output logic [15:0]       pix_clk_5k,
  output logic [15:0]       h_active,
  output logic [15:0]       v_active
);
  localparam int COPY_BYTES = (2 * AW + CNTW) / 8;

  logic       wr_en, cp_shift, cp_last;
  logic [7:0] wr_idx, wr_data;

  vidcmd_parser #(.COPY_BYTES(COPY_BYTES)) u_parser (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .req_pending(req_valid),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .cp_shift(cp_shift), .cp_last(cp_last),
    .sync_err(sync_err), .op_err(op_err)
  );

  vidcmd_copyport #(.AW(AW), .CNTW(CNTW)) u_copy (
    .clk(clk), .rst_n(rst_n),
    .cp_shift(cp_shift), .cp_last(cp_last), .cp_byte(in_data),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_src(req_src), .req_count(req_count), .req_dst(req_dst)
  );

  vidcmd_regfile #(.NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .locked(regs_locked), .live_flat(live_regs)
  );

  assign deep_color = live_regs[8*LOC_DEPTH +: 8] != 8'h00;
  assign blank_code = live_regs[8*LOC_BLANK +: 8];
  assign fb16_base  = {live_regs[8*LOC_FB16 +: 8], live_regs[8*(LOC_FB16+1) +: 8],
                       live_regs[8*(LOC_FB16+2) +: 8]};
  assign fb8_base   = {live_regs[8*LOC_FB8 +: 8], live_regs[8*(LOC_FB8+1) +: 8],
                       live_regs[8*(LOC_FB8+2) +: 8]};
  assign pix_clk_5k = {live_regs[8*(LOC_PCLK+1) +: 8], live_regs[8*LOC_PCLK +: 8]};
  assign h_active   = {live_regs[8*LOC_HACT +: 8], live_regs[8*(LOC_HACT+1) +: 8]};
  assign v_active   = {live_regs[8*LOC_VACT +: 8], live_regs[8*(LOC_VACT+1) +: 8]};

  // R7: input closed while a copy request waits
  a_r7_input_closed: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> !in_ready);
endmodule

// File: tb/test_vidcmd_decoder.sv
`timescale 1ns/1ps
module test_vidcmd_decoder;
  localparam int NREG = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, req_valid;
  logic req_ready = 1'b0;
  logic [23:0] req_src, req_dst;
  logic [7:0] req_count, blank_code;
  logic regs_locked, sync_err, op_err, deep_color;
  logic [NREG*8-1:0] live_regs;
  logic [23:0] fb16_base, fb8_base;
  logic [15:0] pix_clk_5k, h_active, v_active;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  bit hold_off = 1'b0;
  int cyc = 0;
  logic [55:0] expq[$];
  logic [7:0] exp_sh[NREG];
  logic [7:0] exp_lv[NREG];

  always #2.5 clk = ~clk;

  vidcmd_decoder i_vidcmd_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .req_valid(req_valid), .req_ready(req_ready),
    .req_src(req_src), .req_count(req_count), .req_dst(req_dst),
    .regs_locked(regs_locked), .sync_err(sync_err), .op_err(op_err),
    .live_regs(live_regs), .deep_color(deep_color), .blank_code(blank_code),
    .fb16_base(fb16_base), .fb8_base(fb8_base), .pix_clk_5k(pix_clk_5k),
    .h_active(h_active), .v_active(v_active)
  );

  task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NREG*8-1:0] packed_live();
    logic [NREG*8-1:0] v;
    for (int k = 0; k < NREG; k++) v[k*8 +: 8] = exp_lv[k];
    return v;
  endfunction

  task automatic put(input logic [7:0] b);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wreg(input logic [7:0] idx, input logic [7:0] val);
    put(8'hAF); put(8'h20); put(idx); put(val);
    if (idx == 8'hFF) begin
      if (val == 8'hFF) for (int k = 0; k < NREG; k++) exp_lv[k] = exp_sh[k];
    end else if (idx < NREG) exp_sh[idx] = val;
  endtask

  task automatic copy(input logic [23:0] s, input logic [7:0] c, input logic [23:0] d);
    expq.push_back({s, c, d});
    put(8'hAF); put(8'h6A);
    put(s[23:16]); put(s[15:8]); put(s[7:0]); put(c);
    put(d[23:16]); put(d[15:8]); put(d[7:0]);
  endtask

  // monitor: choose ready for this cycle, then score the transfer
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      req_ready = !hold_off && (cyc % 3 != 1);
      #1;
      if (rst_n && req_valid && req_ready) begin
        if (expq.size() == 0) chk("R6 unexpected request", 1, 0);
        else chk("R6 copy fields", {req_src, req_count, req_dst}, expq.pop_front());
      end
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NREG; k++) begin exp_sh[k] = '0; exp_lv[k] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 in_ready", in_ready, 1);
    chk("R1 req_valid", req_valid, 0);
    chk("R1 sync_err", sync_err, 0);
    chk("R1 op_err", op_err, 0);
    chk("R1 locked", regs_locked, 0);
    chk("R1 live", live_regs, 0);

    // R4 gate close
    wreg(8'hFF, 8'h00);
    chk("R4 locked after close", regs_locked, 1);
    wreg(8'h00, 8'h01);
    wreg(8'h20, 8'h12); wreg(8'h21, 8'h34); wreg(8'h22, 8'h56);
    wreg(8'h26, 8'h9A); wreg(8'h27, 8'hBC); wreg(8'h28, 8'hDE);
    wreg(8'h1B, 8'h34); wreg(8'h1C, 8'h12);
    wreg(8'h0F, 8'h05); wreg(8'h10, 8'h00);
    wreg(8'h17, 8'h03); wreg(8'h18, 8'h20);
    wreg(8'h1F, 8'h07);
    chk("R5 live frozen while locked", live_regs, 0);
    wreg(8'hFF, 8'h12);
    chk("R4 neutral gate value keeps lock", regs_locked, 1);
    chk("R4 neutral gate value no commit", live_regs, 0);
    wreg(8'h40, 8'h99);
    wreg(8'hFF, 8'hFF);
    chk("R4 unlocked", regs_locked, 0);
    chk("R3 R4 live after commit", live_regs, packed_live());
    chk("R9 fb16 base", fb16_base, 24'h123456);
    chk("R9 fb8 base", fb8_base, 24'h9ABCDE);
    chk("R10 pixel clock", pix_clk_5k, 16'h1234);
    chk("R10 h_active", h_active, 16'h0500);
    chk("R10 v_active", v_active, 16'h0320);
    chk("R11 deep color", deep_color, 1);
    chk("R11 blank code", blank_code, 8'h07);

    // R5 unlocked write reaches shadow only
    wreg(8'h00, 8'h00);
    chk("R5 live unchanged before gate", deep_color, 1);
    wreg(8'hFF, 8'hFF);
    chk("R11 depth 16", deep_color, 0);
    chk("R3 live after second commit", live_regs, packed_live());

    // R6 copy with a stalling consumer
    copy(24'h010203, 8'h04, 24'h050607);
    wait (expq.size() == 0);
    @(negedge clk);

    // R7 held request
    hold_off = 1'b1;
    copy(24'hA1B2C3, 8'h00, 24'hFFEEDD);
    chk("R6 valid after last byte", req_valid, 1);
    chk("R6 src", req_src, 24'hA1B2C3);
    chk("R6 count", req_count, 8'h00);
    chk("R6 dst", req_dst, 24'hFFEEDD);
    in_valid = 1'b1; in_data = 8'hAF;
    repeat (5) @(negedge clk);
    chk("R7 still valid", req_valid, 1);
    chk("R7 input closed", in_ready, 0);
    chk("R7 fields stable", {req_src, req_count, req_dst}, {24'hA1B2C3, 8'h00, 24'hFFEEDD});
    in_valid = 1'b0;
    hold_off = 1'b0;
    wait (expq.size() == 0);
    @(negedge clk);

    // R8 unknown opcode
    put(8'hAF); put(8'h55);
    chk("R8 op_err pulse", op_err, 1);
    @(negedge clk);
    chk("R8 op_err drops", op_err, 0);
    wreg(8'h05, 8'h77);
    wreg(8'hFF, 8'hFF);
    chk("R8 resumes at sync", live_regs, packed_live());
    chk("R2 no sync error yet", sync_err, 0);

    // R2 garbage before sync
    put(8'h20); put(8'h00); put(8'hFF);
    chk("R2 sync_err set", sync_err, 1);
    wreg(8'h06, 8'h66);
    wreg(8'hFF, 8'hFF);
    chk("R2 garbage dropped", live_regs, packed_live());
    chk("R2 sync_err sticky", sync_err, 1);

    // R6 back-to-back copies
    copy(24'h000001, 8'hFF, 24'h800000);
    copy(24'hFFFFFF, 8'h10, 24'h000000);
    wait (expq.size() == 0);
    repeat (2) @(negedge clk);
    chk("R6 all requests seen", expq.size(), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule